// File: doc/BRIEF.md
# Masked Interrupt Status Controller with Acknowledge Reply

This block keeps an 8-bit interrupt status byte and an 8-bit enable mask, and drives an active-low interrupt line toward the host. Events set status bits: a periodic tick, a reply arriving from the peripheral bus, and data returned by automatic polling of that bus. Bus data is held in a small reply buffer. The host clears status with an acknowledge command. The block answers that command with a byte stream whose content depends on whether bus data is waiting.

An autopoll timer starts when the host loads a nonzero 16-bit device mask through a bus command of a special form. Every poll period it issues a poll request, but only when no bus reply is pending. A poll response that carries data fills the buffer and raises both bus bits. The reply stream is produced by a three-state machine. In ST_IDLE commands are accepted, and an accepted acknowledge takes the transition IDLE->HEAD. ST_HEAD sends the first byte. It takes HEAD->IDLE when there is no buffered data and HEAD->DATA otherwise. ST_DATA sends the buffered bytes, one per cycle, and takes DATA->IDLE on the last one.

Top module: `irq_ack_ctrl`

## Requirements
- R1: `irq_n` is a register. It is low whenever status AND mask is nonzero and high otherwise, and it takes its new value on the same clock edge as the status or mask change that causes it.
- R2: After reset the mask is 0x14 (tick bit 2, bus bit 4), the status is 0, the reply machine is in ST_IDLE, autopoll is off, `irq_n` is 1, and `rsp_valid` and `poll_req` are 0.
- R3: A set-mask command (`cmd_op`=0) with `cmd_len`=1 loads `cmd_args[7:0]` into the mask. Any other length leaves the mask unchanged.
- R4: An acknowledge command (`cmd_op`=1) is acted on only when `cmd_len`=0. Any other length produces no reply and changes no status.
- R5: An acknowledge while status bit 4 is clear replies with one byte, the full status, marked last, and clears the status to 0.
- R6: An acknowledge while status bit 4 is set replies with status AND 0x18 followed by the buffered bytes, oldest first, for a total of buffer length plus 1 bytes, with the last one marked. It clears only bits 3 and 4 and the buffer length, and all other status bits are kept.
- R7: A status bit set by an event in the same cycle as an accepted acknowledge stays set after the acknowledge.
- R8: A bus reply (`bus_rsp_valid`) sets status bit 4 and stores `bus_rsp_len` bytes from `bus_rsp_data`, where byte i is bits [8i+7:8i]. The length is limited to BUF_BYTES.
- R9: A bus command (`cmd_op`=2) is taken as an autopoll setting only when `cmd_len`=4, byte 0 is 0x00 and byte 1 is 0x86. The new mask is {byte 2, byte 3}, high byte first. Any other bus command is ignored.
- R10: A new nonzero autopoll mask restarts the timer, and `poll_req` pulses POLL_PERIOD cycles later and every POLL_PERIOD cycles after that, with `poll_mask` showing the mask. A zero mask stops polling. Writing the mask already held does not disturb the timer phase.
- R11: A poll is issued only when status bit 4 is clear. A poll response with a nonzero length stores the data and sets bits 3 and 4. A response with length 0 changes nothing.
- R12: Commands are accepted only in ST_IDLE. A command that arrives while a reply is streaming is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_evt | input | 1 | Periodic tick event, sets status bit 2 |
| bus_rsp_valid | input | 1 | Bus reply arrival |
| bus_rsp_len | input | LEN_W | Bus reply byte count |
| bus_rsp_data | input | 8*BUF_BYTES | Bus reply bytes, byte 0 in the low bits |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 set-mask, 1 acknowledge, 2 bus command |
| cmd_len | input | 3 | Argument byte count |
| cmd_args | input | 32 | Argument bytes, byte 0 in the low bits |
| rsp_valid | output | 1 | Reply byte valid |
| rsp_data | output | 8 | Reply byte |
| rsp_last | output | 1 | Final reply byte |
| poll_req | output | 1 | One-cycle poll request |
| poll_mask | output | 16 | Current autopoll device mask |
| poll_rsp_valid | input | 1 | Poll response strobe |
| poll_rsp_len | input | LEN_W | Poll response byte count |
| poll_rsp_data | input | 8*BUF_BYTES | Poll response bytes |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A wrong status or mask bit shows on `irq_n` on the same edge that stores it. It shows again, byte for byte, in the very next acknowledge reply. A fault in the buffer or its length appears only when a pending bus reply is acknowledged, as a wrong byte or a misplaced last marker in the stream. A timer phase fault shows as a `poll_req` that arrives early or late, counted against POLL_PERIOD from the edge of the mask write or of the previous poll. A missed gate shows as a poll issued while a bus reply is pending.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;

    localparam int TICK_BIT = 2;
    localparam int AUTO_BIT = 3;
    localparam int BUS_BIT  = 4;

    localparam logic [7:0] BUS_BITS   = 8'h18;
    localparam logic [7:0] RESET_MASK = 8'h14;

    localparam int CMD_LEN_W = 3;
    localparam int ARG_BYTES = 4;

    localparam logic [7:0] AP_SIG0 = 8'h00;
    localparam logic [7:0] AP_SIG1 = 8'h86;

    typedef enum logic [1:0] {
        OP_MASK = 2'd0,
        OP_ACK  = 2'd1,
        OP_BUS  = 2'd2,
        OP_NONE = 2'd3
    } cmd_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HEAD = 2'd1,
        ST_DATA = 2'd2
    } rsp_state_e;

endpackage

// File: rtl/irq_status_regs.sv
module irq_status_regs
    import irq_ack_pkg::*;
#(
    parameter int BUF_BYTES = 4,
    parameter int LEN_W     = $clog2(BUF_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick_i,
    input  logic                   busr_valid_i,
    input  logic [LEN_W-1:0]       busr_len_i,
    input  logic [8*BUF_BYTES-1:0] busr_data_i,
    input  logic                   pollr_valid_i,
    input  logic [LEN_W-1:0]       pollr_len_i,
    input  logic [8*BUF_BYTES-1:0] pollr_data_i,
    input  logic                   mask_wr_i,
    input  logic [7:0]             mask_val_i,
    input  logic                   ack_i,
    output logic [7:0]             status_o,
    output logic [LEN_W-1:0]       buf_len_o,
    output logic [8*BUF_BYTES-1:0] buf_data_o,
    output logic                   irq_n_o
);

    logic [7:0]             status_q, status_d;
    logic [7:0]             mask_q, mask_d;
    logic [LEN_W-1:0]       len_q, len_d;
    logic [8*BUF_BYTES-1:0] data_q, data_d;
    logic                   irq_n_q;

    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] l);
        return (l > LEN_W'(BUF_BYTES)) ? LEN_W'(BUF_BYTES) : l;
    endfunction

    always_comb begin
        status_d = status_q;
        mask_d   = mask_q;
        len_d    = len_q;
        data_d   = data_q;
        if (mask_wr_i) mask_d = mask_val_i;
        if (ack_i) begin
            if (status_q[BUS_BIT]) begin
                status_d = status_q & ~BUS_BITS;
                len_d    = '0;
            end else begin
                status_d = '0;
            end
        end
        if (tick_i) status_d[TICK_BIT] = 1'b1;
        if (busr_valid_i) begin
            status_d[BUS_BIT] = 1'b1;
            len_d             = clamp_len(busr_len_i);
            data_d            = busr_data_i;
        end else if (pollr_valid_i && pollr_len_i != '0) begin
            status_d = status_d | BUS_BITS;
            len_d    = clamp_len(pollr_len_i);
            data_d   = pollr_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            mask_q   <= RESET_MASK;
            len_q    <= '0;
            data_q   <= '0;
            irq_n_q  <= 1'b1;
        end else begin
            status_q <= status_d;
            mask_q   <= mask_d;
            len_q    <= len_d;
            data_q   <= data_d;
            irq_n_q  <= ~|(status_d & mask_d);
        end
    end

    assign status_o   = status_q;
    assign buf_len_o  = len_q;
    assign buf_data_o = data_q;
    assign irq_n_o    = irq_n_q;

    // R3
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr_i |=> $stable(mask_q));

    // R6
    auto_needs_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_q[AUTO_BIT] |-> status_q[BUS_BIT]);

    // R8
    busr_sets_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busr_valid_i |=> status_q[BUS_BIT]);

endmodule

// File: rtl/autopoll_timer.sv
module autopoll_timer #(
    parameter int PERIOD = 30,
    parameter int CNT_W  = $clog2(PERIOD)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_i,
    input  logic [15:0] mask_val_i,
    input  logic        pending_i,
    output logic        poll_req_o,
    output logic [15:0] poll_mask_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [15:0]      mask_q;
    logic [CNT_W-1:0] cnt_q;
    logic             req_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            cnt_q  <= '0;
            req_q  <= 1'b0;
        end else begin
            req_q <= 1'b0;
            if (wr_i && mask_val_i != mask_q) begin
                mask_q <= mask_val_i;
                cnt_q  <= '0;
            end else if (mask_q != '0) begin
                if (cnt_q == LAST) begin
                    cnt_q <= '0;
                    req_q <= !pending_i;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign poll_req_o  = req_q;
    assign poll_mask_o = mask_q;

    // R10
    poll_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |=> !req_q);

    // R10
    poll_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |=> !req_q);

endmodule

// File: rtl/ack_reply_fsm.sv
module ack_reply_fsm
    import irq_ack_pkg::*;
#(
    parameter int BUF_BYTES = 4,
    parameter int LEN_W     = $clog2(BUF_BYTES + 1),
    parameter int IDX_W     = $clog2(BUF_BYTES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ack_i,
    input  logic [7:0]             status_i,
    input  logic [LEN_W-1:0]       buf_len_i,
    input  logic [8*BUF_BYTES-1:0] buf_data_i,
    output logic                   idle_o,
    output logic                   rsp_valid_o,
    output logic [7:0]             rsp_data_o,
    output logic                   rsp_last_o
);

    rsp_state_e                  state_q, state_d;
    logic [7:0]                  head_q;
    logic [BUF_BYTES-1:0][7:0]   snap_q;
    logic [LEN_W-1:0]            dlen_q;
    logic [LEN_W-1:0]            idx_q;
    logic [LEN_W-1:0]            last_idx;

    assign last_idx = dlen_q - LEN_W'(1);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (ack_i) state_d = ST_HEAD;
            ST_HEAD: state_d = (dlen_q == '0) ? ST_IDLE : ST_DATA;
            ST_DATA: if (idx_q == last_idx) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            head_q  <= '0;
            snap_q  <= '0;
            dlen_q  <= '0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && ack_i) begin
                head_q <= status_i[BUS_BIT] ? (status_i & BUS_BITS) : status_i;
                dlen_q <= status_i[BUS_BIT] ? buf_len_i : '0;
                snap_q <= buf_data_i;
                idx_q  <= '0;
            end else if (state_q == ST_DATA) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    always_comb begin
        idle_o      = (state_q == ST_IDLE);
        rsp_valid_o = 1'b0;
        rsp_data_o  = '0;
        rsp_last_o  = 1'b0;
        unique case (state_q)
            ST_HEAD: begin
                rsp_valid_o = 1'b1;
                rsp_data_o  = head_q;
                rsp_last_o  = (dlen_q == '0);
            end
            ST_DATA: begin
                rsp_valid_o = 1'b1;
                rsp_data_o  = snap_q[idx_q[IDX_W-1:0]];
                rsp_last_o  = (idx_q == last_idx);
            end
            default: ;
        endcase
    end

    // R6
    stream_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && !rsp_last_o) |=> rsp_valid_o);

    // R5
    stream_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_last_o |=> !rsp_valid_o);

    // R12
    ack_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |-> idle_o);

    // R6
    last_marks_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_last_o |-> rsp_valid_o);

endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
    import irq_ack_pkg::*;
#(
    parameter int BUF_BYTES   = 4,
    parameter int POLL_PERIOD = 30,
    parameter int LEN_W       = $clog2(BUF_BYTES + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick_evt,
    input  logic                       bus_rsp_valid,
    input  logic [LEN_W-1:0]           bus_rsp_len,
    input  logic [8*BUF_BYTES-1:0]     bus_rsp_data,
    input  logic                       cmd_valid,
    input  logic [1:0]                 cmd_op,
    input  logic [CMD_LEN_W-1:0]       cmd_len,
    input  logic [8*ARG_BYTES-1:0]     cmd_args,
    output logic                       rsp_valid,
    output logic [7:0]                 rsp_data,
    output logic                       rsp_last,
    output logic                       poll_req,
    output logic [15:0]                poll_mask,
    input  logic                       poll_rsp_valid,
    input  logic [LEN_W-1:0]           poll_rsp_len,
    input  logic [8*BUF_BYTES-1:0]     poll_rsp_data,
    output logic                       irq_n
);

    logic                   idle;
    logic                   cmd_ok;
    logic                   mask_wr, ack_go, ap_wr;
    logic [7:0]             status;
    logic [LEN_W-1:0]       buf_len;
    logic [8*BUF_BYTES-1:0] buf_data;

    assign cmd_ok  = cmd_valid && idle;
    assign mask_wr = cmd_ok && (cmd_op == OP_MASK) && (cmd_len == CMD_LEN_W'(1));
    assign ack_go  = cmd_ok && (cmd_op == OP_ACK)  && (cmd_len == '0);
    assign ap_wr   = cmd_ok && (cmd_op == OP_BUS)  && (cmd_len == CMD_LEN_W'(4))
                     && (cmd_args[7:0] == AP_SIG0) && (cmd_args[15:8] == AP_SIG1);

    irq_status_regs #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_evt),
        .busr_valid_i (bus_rsp_valid),
        .busr_len_i   (bus_rsp_len),
        .busr_data_i  (bus_rsp_data),
        .pollr_valid_i(poll_rsp_valid),
        .pollr_len_i  (poll_rsp_len),
        .pollr_data_i (poll_rsp_data),
        .mask_wr_i    (mask_wr),
        .mask_val_i   (cmd_args[7:0]),
        .ack_i        (ack_go),
        .status_o     (status),
        .buf_len_o    (buf_len),
        .buf_data_o   (buf_data),
        .irq_n_o      (irq_n)
    );

    autopoll_timer #(.PERIOD(POLL_PERIOD)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (ap_wr),
        .mask_val_i ({cmd_args[23:16], cmd_args[31:24]}),
        .pending_i  (status[BUS_BIT]),
        .poll_req_o (poll_req),
        .poll_mask_o(poll_mask)
    );

    ack_reply_fsm #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ack_i      (ack_go),
        .status_i   (status),
        .buf_len_i  (buf_len),
        .buf_data_i (buf_data),
        .idle_o     (idle),
        .rsp_valid_o(rsp_valid),
        .rsp_data_o (rsp_data),
        .rsp_last_o (rsp_last)
    );

endmodule

// File: tb/irq_ack_ctrl_bench.sv
module irq_ack_ctrl_bench;

    localparam int P   = 30;
    localparam int BB  = 4;
    localparam int LW  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_evt = 1'b0;
    logic          bus_rsp_valid = 1'b0;
    logic [LW-1:0] bus_rsp_len = '0;
    logic [31:0]   bus_rsp_data = '0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = '0;
    logic [2:0]    cmd_len = '0;
    logic [31:0]   cmd_args = '0;
    logic          rsp_valid, rsp_last, poll_req, irq_n;
    logic [7:0]    rsp_data;
    logic [15:0]   poll_mask;
    logic          poll_rsp_valid = 1'b0;
    logic [LW-1:0] poll_rsp_len = '0;
    logic [31:0]   poll_rsp_data = '0;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    irq_ack_ctrl #(.BUF_BYTES(BB), .POLL_PERIOD(P)) u_irq_ack_ctrl (
        .clk(clk), .rst_n(rst_n), .tick_evt(tick_evt),
        .bus_rsp_valid(bus_rsp_valid), .bus_rsp_len(bus_rsp_len), .bus_rsp_data(bus_rsp_data),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_len(cmd_len), .cmd_args(cmd_args),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last),
        .poll_req(poll_req), .poll_mask(poll_mask),
        .poll_rsp_valid(poll_rsp_valid), .poll_rsp_len(poll_rsp_len), .poll_rsp_data(poll_rsp_data),
        .irq_n(irq_n)
    );

    typedef struct packed {
        logic       tick;
        logic       cv;
        logic [1:0] op;
        logic [2:0] len;
        logic [7:0] a0;
        logic       irqn;
        logic       rv;
        logic [7:0] rb;
    } vec_t;

    localparam vec_t VECS [0:9] = '{
        {1'b1, 1'b0, 2'd0, 3'd0, 8'h00, 1'b0, 1'b0, 8'h00},
        {1'b0, 1'b1, 2'd0, 3'd1, 8'h00, 1'b1, 1'b0, 8'h00},
        {1'b0, 1'b1, 2'd0, 3'd2, 8'hFF, 1'b1, 1'b0, 8'h00},
        {1'b0, 1'b1, 2'd0, 3'd1, 8'h04, 1'b0, 1'b0, 8'h00},
        {1'b0, 1'b1, 2'd1, 3'd1, 8'h00, 1'b0, 1'b0, 8'h00},
        {1'b0, 1'b1, 2'd1, 3'd0, 8'h00, 1'b1, 1'b1, 8'h04},
        {1'b1, 1'b0, 2'd0, 3'd0, 8'h00, 1'b0, 1'b0, 8'h00},
        {1'b0, 1'b1, 2'd0, 3'd1, 8'h08, 1'b1, 1'b0, 8'h00},
        {1'b0, 1'b1, 2'd1, 3'd0, 8'h00, 1'b1, 1'b1, 8'h04},
        {1'b0, 1'b0, 2'd0, 3'd0, 8'h00, 1'b1, 1'b0, 8'h00}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic send_cmd(input logic [1:0] op, input logic [2:0] len, input logic [31:0] args);
        cmd_valid = 1'b1; cmd_op = op; cmd_len = len; cmd_args = args;
        step();
        cmd_valid = 1'b0;
    endtask

    task automatic expect_stream(input string req, input int n, input logic [39:0] bytes);
        for (int i = 0; i < n; i++) begin
            check(req, {23'd0, rsp_valid, rsp_data}, {23'd0, 1'b1, bytes[8*i +: 8]});
            check(req, {31'd0, rsp_last}, {31'd0, (i == n - 1) ? 1'b1 : 1'b0});
            step();
        end
        check(req, {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic bus_reply(input logic [2:0] len, input logic [31:0] data);
        bus_rsp_valid = 1'b1; bus_rsp_len = len; bus_rsp_data = data;
        step();
        bus_rsp_valid = 1'b0;
    endtask

    task automatic poll_reply(input logic [2:0] len, input logic [31:0] data);
        poll_rsp_valid = 1'b1; poll_rsp_len = len; poll_rsp_data = data;
        step();
        poll_rsp_valid = 1'b0;
    endtask

    task automatic wait_poll(output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (!poll_req && n < 4 * P);
    endtask

    task automatic count_polls(input int cycles, output int hits);
        hits = 0;
        for (int i = 0; i < cycles; i++) begin
            step();
            if (poll_req) hits++;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int n;
        int hits;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R2 reset state
        check("R2 irq_n", {31'd0, irq_n}, 32'd1);
        check("R2 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        check("R2 poll_req", {31'd0, poll_req}, 32'd0);
        check("R2 poll_mask", {16'd0, poll_mask}, 32'd0);

        // R1 R3 R4 R5 vector walk
        for (int i = 0; i < 10; i++) begin
            tick_evt  = VECS[i].tick;
            cmd_valid = VECS[i].cv;
            cmd_op    = VECS[i].op;
            cmd_len   = VECS[i].len;
            cmd_args  = {24'd0, VECS[i].a0};
            step();
            tick_evt  = 1'b0;
            cmd_valid = 1'b0;
            check($sformatf("R1/R3/R4 vec %0d irq_n", i), {31'd0, irq_n}, {31'd0, VECS[i].irqn});
            check($sformatf("R4/R5 vec %0d rsp_valid", i), {31'd0, rsp_valid}, {31'd0, VECS[i].rv});
            if (VECS[i].rv) begin
                check($sformatf("R5 vec %0d data", i), {24'd0, rsp_data}, {24'd0, VECS[i].rb});
                check($sformatf("R5 vec %0d last", i), {31'd0, rsp_last}, 32'd1);
                step();
            end
        end

        // R6 R8 pending bus reply acknowledge
        send_cmd(2'd0, 3'd1, 32'h14);
        tick_evt = 1'b1; step(); tick_evt = 1'b0;
        bus_reply(3'd2, 32'h0000BBAA);
        check("R8 irq_n after bus reply", {31'd0, irq_n}, 32'd0);
        send_cmd(2'd1, 3'd0, 32'h0);
        expect_stream("R6 bus ack", 3, 40'h00_0000BBAA_10 >> 0);
        check("R6 tick kept irq_n", {31'd0, irq_n}, 32'd0);
        send_cmd(2'd1, 3'd0, 32'h0);
        check("R5 cleared irq_n", {31'd0, irq_n}, 32'd1);
        expect_stream("R6 tick after bus ack", 1, 40'h04);

        // R7 event coincident with acknowledge
        tick_evt = 1'b1; step(); tick_evt = 1'b0;
        tick_evt = 1'b1;
        send_cmd(2'd1, 3'd0, 32'h0);
        tick_evt = 1'b0;
        check("R7 irq_n held", {31'd0, irq_n}, 32'd0);
        expect_stream("R7 reply", 1, 40'h04);
        send_cmd(2'd1, 3'd0, 32'h0);
        expect_stream("R7 survivor", 1, 40'h04);

        // R6 zero-length buffer, R8 length clamp
        bus_reply(3'd0, 32'h0);
        check("R8 zero-len pending irq_n", {31'd0, irq_n}, 32'd0);
        send_cmd(2'd1, 3'd0, 32'h0);
        expect_stream("R6 zero-len", 1, 40'h10);
        bus_reply(3'd7, 32'h44332211);
        send_cmd(2'd1, 3'd0, 32'h0);
        expect_stream("R8 clamp", 5, 40'h44332211_10);

        // R12 command during reply is ignored
        bus_reply(3'd3, 32'h00CCBBAA);
        send_cmd(2'd1, 3'd0, 32'h0);
        check("R12 head", {24'd0, rsp_data}, 32'h10);
        send_cmd(2'd0, 3'd1, 32'h00);
        check("R12 byte1", {24'd0, rsp_data}, 32'hAA);
        step();
        check("R12 byte2", {24'd0, rsp_data}, 32'hBB);
        step();
        check("R12 byte3 last", {23'd0, rsp_last, rsp_data}, 32'h1CC);
        step();
        tick_evt = 1'b1; step(); tick_evt = 1'b0;
        check("R12 mask unchanged", {31'd0, irq_n}, 32'd0);
        send_cmd(2'd1, 3'd0, 32'h0);
        expect_stream("R12 clear", 1, 40'h04);

        // R9 R10 R11 autopoll start and response
        send_cmd(2'd2, 3'd4, 32'h3412_8600);
        wait_poll(n);
        check("R10 first poll delay", n, P);
        check("R9 poll mask", {16'd0, poll_mask}, 32'h1234);
        poll_reply(3'd1, 32'h5C);
        check("R11 poll data irq_n", {31'd0, irq_n}, 32'd0);
        send_cmd(2'd1, 3'd0, 32'h0);
        expect_stream("R11 auto ack", 2, 40'h5C18);
        wait_poll(n);
        poll_reply(3'd0, 32'hFF);
        check("R11 empty response", {31'd0, irq_n}, 32'd1);

        // R11 no poll while pending
        wait_poll(n);
        poll_reply(3'd1, 32'h77);
        count_polls(2 * P + 4, hits);
        check("R11 gated polls", hits, 0);
        send_cmd(2'd1, 3'd0, 32'h0);
        expect_stream("R11 gated ack", 2, 40'h7718);

        // R10 same mask keeps phase
        wait_poll(n);
        n = 0;
        repeat (9) begin step(); n++; end
        send_cmd(2'd2, 3'd4, 32'h3412_8600);
        n++;
        while (!poll_req && n < 4 * P) begin step(); n++; end
        check("R10 same mask phase", n, P);

        // R10 new mask restarts
        n = 0;
        repeat (9) begin step(); n++; end
        send_cmd(2'd2, 3'd4, 32'h0100_8600);
        n++;
        while (!poll_req && n < 4 * P) begin step(); n++; end
        check("R10 restart delay", n, P + 10);
        check("R10 new mask", {16'd0, poll_mask}, 32'h0001);

        // R9 malformed autopoll commands ignored
        send_cmd(2'd2, 3'd3, 32'h0000_8600);
        send_cmd(2'd2, 3'd4, 32'h0000_8700);
        count_polls(P, hits);
        check("R9 malformed ignored", hits, 1);
        check("R9 mask kept", {16'd0, poll_mask}, 32'h0001);

        // R10 zero mask stops
        send_cmd(2'd2, 3'd4, 32'h0000_8600);
        count_polls(2 * P + 2, hits);
        check("R10 stopped", hits, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule